// File: doc/BRIEF.md
# UART Receive Byte Buffer with Fill-Level Interrupts

This block sits between a UART receiver (or a transmit-to-receive loopback path) and the register block that serves data-register reads. Incoming characters are written into a small byte queue. Characters leave the queue one at a time when the register block reads the data register. Two raw interrupt bits come out of the block. The first, the fill-level bit, goes high when a new character brings the occupancy from below a programmable threshold up to or past it. The second, the data-present bit, stays high while characters wait in the queue. Both bits are raw: masking, clearing by software and register mapping stay in the neighbouring register block.

A mode input switches the buffer between two settings. In queue mode it holds the full depth, and a 3-bit select picks the threshold as a fraction of that depth. In single mode it holds one character and the threshold is one. When the mode changes, the contents are thrown away.

The input side follows valid/ready. `in_ready` is high whenever a byte can be stored. A serial receiver cannot wait, so a byte offered while `in_ready` is low is not held for a retry. It is dropped and flagged on `overrun`. The output side follows valid/ready as well. `out_valid` shows that a character is waiting and `out_data` shows it. A cycle with `out_valid` and `out_ready` both high removes that character. `out_ready` while empty has no effect.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the buffer is in single mode, `empty`=1, `full`=0, `level`=0, `irq_level`=0, `irq_data`=0, `overrun`=0, `in_ready`=1 and `out_valid`=0.
- R2: Characters leave in the order they were accepted. `out_valid` equals not `empty`. `out_data` is 0 while empty, and `out_ready` on an empty buffer leaves `level` and the contents unchanged.
- R3: Capacity is DEPTH (16) characters while `fifo_en`=1 and one character while `fifo_en`=0. `full` is 1 exactly when `level` equals the capacity, and `in_ready` equals not `full`.
- R4: A byte offered while full, with no removal in the same cycle, is discarded. `overrun` is high for exactly the following cycle, and `level` and the stored contents are unchanged.
- R5: In queue mode `thr_sel` values 0,1,2,3,4 give thresholds of 2,4,8,12,14 characters, and values 5,6,7 give 16. In single mode the threshold is 1.
- R6: `irq_level` becomes 1 one cycle after an accepted byte raises the occupancy from below the threshold to at or above it. It never rises otherwise.
- R7: `irq_level` becomes 0 one cycle after a removal that leaves the occupancy below the threshold. A removal that leaves it at or above the threshold keeps the bit set.
- R8: `irq_data` becomes 1 after any accepted byte and 0 after a removal that leaves the buffer empty.
- R9: One cycle after `fifo_en` changes, the buffer is empty with both interrupt bits 0 and the new capacity in force. A push or pop offered in that cycle is ignored.
- R10: An accepted byte together with a removal in the same cycle leaves `level` unchanged, and this includes the full case, where the byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = queue mode (full depth), 0 = single-character mode |
| thr_sel | input | 3 | Fill-level threshold select |
| in_valid | input | 1 | Incoming character offered |
| in_data | input | 8 | Incoming character |
| in_ready | output | 1 | Space available; bytes offered while low are dropped |
| out_valid | output | 1 | A character is waiting |
| out_data | output | 8 | Oldest waiting character, 0 when empty |
| out_ready | input | 1 | Data-register read strobe, removes the head when out_valid |
| level | output | 5 | Current occupancy |
| full | output | 1 | Occupancy equals capacity |
| empty | output | 1 | Occupancy is zero |
| overrun | output | 1 | One-cycle pulse after a dropped byte |
| irq_level | output | 1 | Raw fill-level interrupt |
| irq_data | output | 1 | Raw data-present interrupt |

## Verification
On every cycle the assertions check that occupancy never exceeds the capacity, that a simultaneous push and pop holds the count, that a refused byte raises overrun without changing the count, that the last removal drops the data-present bit, that the fill-level bit only rises on an accepted push, and that a mode change flushes the buffer. The bench scenarios show what needs a sequence of operations to see. These are first-in first-out ordering, each of the eight threshold selections measured by counting pushes until the interrupt rises, the fill-level bit staying set while pops remain at or above the threshold, and the difference in capacity between the two modes.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  // Threshold select codes for the fill-level interrupt
  typedef enum logic [2:0] {
    THR_EIGHTH   = 3'd0,
    THR_QUARTER  = 3'd1,
    THR_HALF     = 3'd2,
    THR_3QUARTER = 3'd3,
    THR_7EIGHTH  = 3'd4
  } thr_code_e;

  // Threshold in characters for a given select and capacity
  function automatic int unsigned thr_of(input logic [2:0] sel, input int unsigned depth);
    case (sel)
      THR_EIGHTH:   thr_of = depth / 8;
      THR_QUARTER:  thr_of = depth / 4;
      THR_HALF:     thr_of = depth / 2;
      THR_3QUARTER: thr_of = (depth * 3) / 4;
      THR_7EIGHTH:  thr_of = (depth * 7) / 8;
      default:      thr_of = depth;
    endcase
  endfunction
endpackage

// File: rtl/rxb_thresh.sv
module rxb_thresh #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          mode_q,
  input  logic [2:0]    sel,
  output logic [CW-1:0] cap,
  output logic [CW-1:0] thr
);
  import rxb_pkg::*;

  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] frac_tbl [8];

  // Precomputed fractional thresholds, one per select code
  for (genvar g = 0; g < 8; g++) begin : g_tbl
    localparam int unsigned T = thr_of(3'(g), DEPTH);
    assign frac_tbl[g] = (T == 0) ? ONE : CW'(T);
  end

  always_comb begin
    cap = mode_q ? FULL : ONE;
    thr = mode_q ? frac_tbl[sel] : ONE;
  end

  // R5: threshold always within 1..capacity
  always_comb begin
    a_r5_thr_range: assert (thr >= ONE && thr <= cap)
      else $error("threshold out of range");
  end
endmodule

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] head
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr) wr_ptr <= wr_ptr + PW'(1);
      if (rd) rd_ptr <= rd_ptr + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= wdata;
  end

  assign head = mem[rd_ptr];

  // R2: the read pointer moves only on a removal or a flush
  a_r2_rdptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !flush) |=> $stable(rd_ptr));
  // R4: the write pointer moves only on an accepted byte or a flush
  a_r4_wrptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !flush) |=> $stable(wr_ptr));
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] thr,
  output logic          mode_q,
  output logic          flush,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] cnt_q,
  output logic          full_q,
  output logic          empty_q,
  output logic          ovr_q,
  output logic          irq_lvl_q,
  output logic          irq_dat_q
);
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    flush   = (mode_en != mode_q);
    pop_ok  = out_ready && !empty_q && !flush;
    push_ok = in_valid && !flush && (!full_q || pop_ok);
    if (flush) cnt_nxt = '0;
    else       cnt_nxt = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      cnt_q     <= '0;
      full_q    <= 1'b0;
      empty_q   <= 1'b1;
      ovr_q     <= 1'b0;
      irq_lvl_q <= 1'b0;
      irq_dat_q <= 1'b0;
    end else begin
      mode_q  <= mode_en;
      cnt_q   <= cnt_nxt;
      full_q  <= !flush && (cnt_nxt == cap);
      empty_q <= (cnt_nxt == '0);
      ovr_q   <= in_valid && !flush && !push_ok;
      if (flush)
        irq_lvl_q <= 1'b0;
      else if (push_ok && cnt_q < thr && cnt_nxt >= thr)
        irq_lvl_q <= 1'b1;
      else if (pop_ok && cnt_nxt < thr)
        irq_lvl_q <= 1'b0;
      if (flush)
        irq_dat_q <= 1'b0;
      else if (push_ok)
        irq_dat_q <= 1'b1;
      else if (pop_ok && cnt_nxt == '0)
        irq_dat_q <= 1'b0;
    end
  end

  // R3: occupancy bounded by capacity
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cap);
  // R10: simultaneous push and pop hold the count
  a_r10_push_pop_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (cnt_q == $past(cnt_q)));
  // R4: refused byte flags overrun and leaves the count
  a_r4_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full_q && !out_ready && !flush) |=> (ovr_q && cnt_q == $past(cnt_q)));
  // R8: last removal drops the data-present bit
  a_r8_data_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok && cnt_q == CW'(1)) |=> (!irq_dat_q && empty_q));
  // R6: fill-level bit rises only after an accepted byte
  a_r6_level_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lvl_q) |-> $past(push_ok));
  // R9: mode change flushes contents and interrupts
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && !irq_lvl_q && !irq_dat_q));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [2:0]    thr_sel,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          overrun,
  output logic          irq_level,
  output logic          irq_data
);
  logic          mode_q, flush, push_ok, pop_ok;
  logic [CW-1:0] cap, thr;
  logic [DW-1:0] head;

  rxb_thresh #(.DEPTH(DEPTH), .CW(CW)) u_thresh (
    .mode_q(mode_q), .sel(thr_sel), .cap(cap), .thr(thr)
  );

  rxb_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_en(fifo_en),
    .in_valid(in_valid), .out_ready(out_ready),
    .cap(cap), .thr(thr),
    .mode_q(mode_q), .flush(flush), .push_ok(push_ok), .pop_ok(pop_ok),
    .cnt_q(level), .full_q(full), .empty_q(empty), .ovr_q(overrun),
    .irq_lvl_q(irq_level), .irq_dat_q(irq_data)
  );

  rxb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr(push_ok), .wdata(in_data), .rd(pop_ok), .head(head)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = empty ? '0 : head;

  // R2: out_valid and out_data agree with the empty flag
  a_r2_empty_data: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (out_data == '0 && !out_valid));
endmodule

// File: tb/uart_rx_buffer_bench.sv
`timescale 1ns/1ps
module uart_rx_buffer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [2:0] thr_sel = 3'd0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  logic [4:0] level;
  logic       full, empty, overrun, irq_level, irq_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_buffer u_uart_rx_buffer (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_sel(thr_sel),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .level(level), .full(full), .empty(empty), .overrun(overrun),
    .irq_level(irq_level), .irq_data(irq_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle with the given strobes; returns after the edge, at negedge
  task automatic step(input bit pv, input logic [7:0] pd, input bit pr);
    @(negedge clk);
    in_valid  = pv;
    in_data   = pd;
    out_ready = pr;
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
  endtask

  task automatic set_mode(input bit en);
    @(negedge clk);
    fifo_en = en;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) if (!empty) step(1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "level", level, 0);
    chk("R1", "irq_level", irq_level, 0);
    chk("R1", "irq_data", irq_data, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "out_valid", out_valid, 0);
  endtask

  task automatic t_pop_empty();
    step(1'b0, 8'h00, 1'b1);
    chk("R2", "level after pop on empty", level, 0);
    chk("R2", "out_data while empty", out_data, 0);
    step(1'b1, 8'h5A, 1'b0);
    chk("R2", "head after push", out_data, 8'h5A);
    chk("R2", "out_valid after push", out_valid, 1);
    step(1'b0, 8'h00, 1'b1);
    chk("R2", "empty after pop", empty, 1);
  endtask

  task automatic t_single_mode();
    step(1'b1, 8'h11, 1'b0);
    chk("R3", "single level", level, 1);
    chk("R3", "single full", full, 1);
    chk("R3", "single in_ready", in_ready, 0);
    chk("R5", "single threshold 1 -> irq_level", irq_level, 1);
    chk("R8", "irq_data after push", irq_data, 1);
    step(1'b1, 8'h22, 1'b0);
    chk("R4", "overrun pulse", overrun, 1);
    chk("R4", "level after drop", level, 1);
    chk("R4", "head kept", out_data, 8'h11);
    @(negedge clk);
    chk("R4", "overrun one cycle", overrun, 0);
    step(1'b0, 8'h00, 1'b1);
    chk("R7", "irq_level after pop", irq_level, 0);
    chk("R8", "irq_data after last pop", irq_data, 0);
  endtask

  task automatic t_mode_flush();
    step(1'b1, 8'h33, 1'b0);
    @(negedge clk);
    fifo_en = 1'b1;
    in_valid = 1'b1;
    in_data = 8'h44;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "level after enable", level, 0);
    chk("R9", "irq_data after enable", irq_data, 0);
    chk("R9", "irq_level after enable", irq_level, 0);
    chk("R9", "full after enable", full, 0);
  endtask

  task automatic t_fill_order();
    thr_sel = 3'd2;
    for (int k = 1; k <= 16; k++) begin
      step(1'b1, 8'(k * 7 + 3), 1'b0);
      chk("R6", $sformatf("irq_level after push %0d", k), irq_level, int'(k >= 8));
    end
    chk("R3", "full at 16", full, 1);
    chk("R3", "level 16", level, 16);
    chk("R3", "in_ready when full", in_ready, 0);
    step(1'b1, 8'hEE, 1'b0);
    chk("R4", "overrun queue mode", overrun, 1);
    chk("R4", "level unchanged", level, 16);
    for (int k = 1; k <= 16; k++) begin
      chk("R2", $sformatf("order %0d", k), out_data, (k * 7 + 3) & 255);
      step(1'b0, 8'h00, 1'b1);
      chk("R7", $sformatf("irq_level with %0d left", 16 - k), irq_level, int'(16 - k >= 8));
    end
    chk("R8", "irq_data drained", irq_data, 0);
  endtask

  task automatic t_thresholds();
    int exp_thr [8] = '{2, 4, 8, 12, 14, 16, 16, 16};
    for (int s = 0; s < 8; s++) begin
      int n;
      @(negedge clk);
      thr_sel = 3'(s);
      n = 0;
      while (!irq_level && n < 17) begin
        step(1'b1, 8'(s), 1'b0);
        n++;
      end
      chk("R5", $sformatf("threshold for select %0d", s), n, exp_thr[s]);
      drain();
    end
  endtask

  task automatic t_push_pop();
    step(1'b1, 8'hA1, 1'b0);
    step(1'b1, 8'hA2, 1'b0);
    step(1'b1, 8'hA3, 1'b0);
    step(1'b1, 8'hA4, 1'b1);
    chk("R10", "level steady", level, 3);
    chk("R10", "head advanced", out_data, 8'hA2);
    drain();
    for (int k = 0; k < 16; k++) step(1'b1, 8'(k), 1'b0);
    step(1'b1, 8'hF0, 1'b1);
    chk("R10", "full push+pop level", level, 16);
    chk("R10", "full push+pop no overrun", overrun, 0);
    for (int k = 1; k < 16; k++) step(1'b0, 8'h00, 1'b1);
    chk("R10", "accepted byte at tail", out_data, 8'hF0);
    drain();
    set_mode(1'b0);
    chk("R9", "level after disable", level, 0);
    step(1'b1, 8'h01, 1'b0);
    chk("R3", "capacity 1 after disable", full, 1);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pop_empty();
    t_single_mode();
    t_mode_flush();
    t_fill_order();
    t_thresholds();
    t_push_pop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule